// File: doc/BRIEF.md
# Configuration Byte Readback Window

This block lets software running on a small controller read its stored configuration: one protection byte and three option bytes (low, high and extended). Software writes a control register with two specific bits set. That opens a short window counted in clock cycles. A program-memory load issued inside the window does not return program memory. It returns the configuration byte picked by the low bits of the load's 16-bit pointer. The window closes by itself: when the redirected load completes, when a store is issued, or when the window runs out.

Outside the window every load is a plain program-memory read. The byte presented on `pmem_rdata` in the load cycle comes back on `rd_data` one cycle later. The stored configuration arrives on input pins, with a programmed bit held as 0 and an unprogrammed bit held as 1. The block passes these values through without inverting them.

Top module: `cfg_readback_window`

## Requirements
- R1: After a synchronous active-low reset, `ctl_bits` reads 0x00 and `rd_valid` is 0.
- R2: A control write whose data has both bit 3 (select) and bit 0 (go) set arms the window, and `ctl_bits` then reads 0x09. A write with any other data leaves `ctl_bits` at 0x00.
- R3: A load sampled on any of the first three clock edges after the arming edge is redirected. `rd_valid` is 1 and `rd_data` holds the configuration byte in the cycle after the load edge.
- R4: During a redirected load, pointer value 0x0000 returns the low option byte, 0x0001 the protection byte, 0x0002 the extended option byte and 0x0003 the high option byte.
- R5: The protection byte carries the 6 stored protection bits in bits 5..0 and reads 1 in bits 7..6. The extended byte carries its 3 stored bits in bits 2..0 and reads 1 in bits 7..3. Stored bit values pass through unchanged, so a programmed bit reads 0.
- R6: A load inside the window with a pointer above 0x0003 returns 0xFF and still closes the window.
- R7: After a redirected load, `ctl_bits` reads 0x00, and a later load returns program memory.
- R8: If neither a load nor a store is sampled on the three edges after arming, `ctl_bits` reads 0x00 after the third edge, and a load on the fourth edge returns program memory.
- R9: A store sampled while armed closes the window and changes no configuration value. A later load returns program memory, and a fresh window still returns the unchanged stored bytes.
- R10: A load while the window is closed returns the `pmem_rdata` value sampled on the load edge, one cycle later.
- R11: The window count starts on the edge after the arming write. A load sampled on the same edge as the arming write is a normal program-memory read, and the window stays open afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_bits | output | 8 | Control register read value |
| ld_issue | input | 1 | Program-memory load issued this cycle |
| ld_ptr | input | 16 | Address pointer of the load |
| pmem_rdata | input | 8 | Program-memory byte for the current load |
| st_issue | input | 1 | Program-memory store issued this cycle |
| lock_bits | input | 6 | Stored protection bits (0 = programmed) |
| fuse_low | input | 8 | Stored low option byte |
| fuse_high | input | 8 | Stored high option byte |
| fuse_ext | input | 3 | Stored extended option bits |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 8 | Load result byte |

## Verification
The hardest cases to reach are the window's last edge and the first edge after it. At those edges the outcome turns on one cycle. The bench counts exact negedge-driven steps after the arming write. It places a load on the third edge, which must be redirected. It places another load on the fourth edge, which must be a normal read. It also lines a load up on the arming edge itself. A store sent in place of the load, followed by a load and then a fresh window, shows that a store both closes the window and leaves the stored bytes as they were.

// File: rtl/cfg_rb_pkg.sv
// Package: shared constants and types for the configuration readback block.
// Assumes an 8-bit data path and a register with a select bit and a go bit.
package cfg_rb_pkg;
    localparam int DATA_W  = 8;
    localparam int SEL_BIT = 3;
    localparam int GO_BIT  = 0;

    // Byte chosen by the two low pointer bits during a redirected load
    typedef enum logic [1:0] {
        SRC_LOW  = 2'd0,
        SRC_LOCK = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_HIGH = 2'd3
    } cfg_src_e;
endpackage

// File: rtl/cfg_win_ctrl.sv
// Module: holds the armed state and counts the readback window.
// Assumes at most one control write per cycle. A write has priority over
// load, store and expiry on the same edge. Only a both-bits write arms.
module cfg_win_ctrl
    import cfg_rb_pkg::*;
#(
    parameter int WIN_LD = 3,
    parameter int WIN_ST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ld_issue,
    input  logic              st_issue,
    output logic              armed,
    output logic [DATA_W-1:0] ctl_bits
);
    localparam int HOLD = (WIN_LD < WIN_ST) ? WIN_LD : WIN_ST;
    localparam int CW   = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic          arm_req;
    logic [CW-1:0] age;

    // Decode an arming write
    always_comb begin
        arm_req = ctl_wr && ctl_wdata[SEL_BIT] && ctl_wdata[GO_BIT];
    end

    // Armed flag and window age: set on arming, clear on load, store or expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            age   <= '0;
        end else if (ctl_wr) begin
            armed <= arm_req;
            age   <= '0;
        end else if (armed) begin
            if (ld_issue || st_issue || age == LAST) begin
                armed <= 1'b0;
                age   <= '0;
            end else begin
                age <= age + 1'b1;
            end
        end
    end

    // Register read value built from the armed flag
    always_comb begin
        ctl_bits          = '0;
        ctl_bits[SEL_BIT] = armed;
        ctl_bits[GO_BIT]  = armed;
    end

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> armed && age == '0);
    p_no_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !arm_req) |=> !armed);
    p_hit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ld_issue && !ctl_wr) |=> !armed);
    p_store_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_issue && !ctl_wr) |=> !armed);
    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && age == LAST && !ld_issue && !st_issue && !ctl_wr) |=> !armed);
    p_age_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> age <= LAST);
endmodule

// File: rtl/cfg_byte_mux.sv
// Module: picks the configuration byte for a redirected load.
// Assumes stored bits arrive with 0 = programmed. Pads the narrow bytes with 1s.
// A pointer above the last code gives all ones.
module cfg_byte_mux
    import cfg_rb_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 6,
    parameter int EXT_W  = 3
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [LOCK_W-1:0] lock_bits,
    input  logic [DATA_W-1:0] fuse_low,
    input  logic [DATA_W-1:0] fuse_high,
    input  logic [EXT_W-1:0]  fuse_ext,
    output logic [DATA_W-1:0] cfg_byte
);
    localparam int SEL_W = 2;

    logic [DATA_W-1:0] lock_byte;
    logic [DATA_W-1:0] ext_byte;
    logic              out_of_range;
    cfg_src_e          src;

    // Pad the narrow bytes with ones above their stored bits
    generate
        if (LOCK_W < DATA_W) begin : g_lock_pad
            assign lock_byte = {{(DATA_W-LOCK_W){1'b1}}, lock_bits};
        end else begin : g_lock_full
            assign lock_byte = lock_bits[DATA_W-1:0];
        end
        if (EXT_W < DATA_W) begin : g_ext_pad
            assign ext_byte = {{(DATA_W-EXT_W){1'b1}}, fuse_ext};
        end else begin : g_ext_full
            assign ext_byte = fuse_ext[DATA_W-1:0];
        end
    endgenerate

    // Split the pointer into a range flag and a source code
    always_comb begin
        out_of_range = |ptr[PTR_W-1:SEL_W];
        src          = cfg_src_e'(ptr[SEL_W-1:0]);
    end

    // Select the byte
    always_comb begin
        if (out_of_range) begin
            cfg_byte = '1;
        end else begin
            unique case (src)
                SRC_LOW:  cfg_byte = fuse_low;
                SRC_LOCK: cfg_byte = lock_byte;
                SRC_EXT:  cfg_byte = ext_byte;
                SRC_HIGH: cfg_byte = fuse_high;
                default:  cfg_byte = '1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_rd_port.sv
// Module: registers the load result, either redirected or program memory.
// Assumes the redirect decision and both candidate bytes are valid in the load cycle.
module cfg_rd_port
    import cfg_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_issue,
    input  logic              redirect,
    input  logic [DATA_W-1:0] cfg_byte,
    input  logic [DATA_W-1:0] pmem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // Capture one result per load, and hold the data between loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= ld_issue;
            if (ld_issue) begin
                rd_data <= redirect ? cfg_byte : pmem_rdata;
            end
        end
    end

    p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_issue |=> rd_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_issue |=> $stable(rd_data));
endmodule

// File: rtl/cfg_readback_window.sv
// Module: top of the configuration readback window.
// A load inside the timed window returns a configuration byte instead of
// program memory. Assumes single-cycle load and store strobes.
module cfg_readback_window
    import cfg_rb_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 6,
    parameter int EXT_W  = 3,
    parameter int WIN_LD = 3,
    parameter int WIN_ST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_bits,
    input  logic              ld_issue,
    input  logic [PTR_W-1:0]  ld_ptr,
    input  logic [7:0]        pmem_rdata,
    input  logic              st_issue,
    input  logic [LOCK_W-1:0] lock_bits,
    input  logic [7:0]        fuse_low,
    input  logic [7:0]        fuse_high,
    input  logic [EXT_W-1:0]  fuse_ext,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    logic              armed;
    logic [DATA_W-1:0] cfg_byte;

    cfg_win_ctrl #(.WIN_LD(WIN_LD), .WIN_ST(WIN_ST)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ld_issue  (ld_issue),
        .st_issue  (st_issue),
        .armed     (armed),
        .ctl_bits  (ctl_bits)
    );

    cfg_byte_mux #(.PTR_W(PTR_W), .LOCK_W(LOCK_W), .EXT_W(EXT_W)) i_mux (
        .ptr       (ld_ptr),
        .lock_bits (lock_bits),
        .fuse_low  (fuse_low),
        .fuse_high (fuse_high),
        .fuse_ext  (fuse_ext),
        .cfg_byte  (cfg_byte)
    );

    cfg_rd_port i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_issue   (ld_issue),
        .redirect   (armed),
        .cfg_byte   (cfg_byte),
        .pmem_rdata (pmem_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    p_far_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue && armed && |ld_ptr[PTR_W-1:2]) |=> rd_data == 8'hFF);
    p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue && !armed) |=> rd_data == $past(pmem_rdata));
    p_lock_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue && armed && ld_ptr == 16'h0001) |=> rd_data[7:6] == 2'b11);
endmodule

// File: tb/test_cfg_readback_window.sv
`timescale 1ns/1ps
module test_cfg_readback_window;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr;
    logic [7:0]  ctl_wdata;
    logic [7:0]  ctl_bits;
    logic        ld_issue;
    logic [15:0] ld_ptr;
    logic [7:0]  pmem_rdata;
    logic        st_issue;
    logic [5:0]  lock_bits;
    logic [7:0]  fuse_low;
    logic [7:0]  fuse_high;
    logic [2:0]  fuse_ext;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] PM   = 8'h3C;
    localparam logic [7:0] LOW  = 8'h62;
    localparam logic [7:0] HIGH = 8'h99;
    localparam logic [5:0] LOCK = 6'b101100;
    localparam logic [2:0] EXT  = 3'b101;

    always #2.5 clk = ~clk;

    cfg_readback_window i_cfg_readback_window (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_bits(ctl_bits), .ld_issue(ld_issue), .ld_ptr(ld_ptr),
        .pmem_rdata(pmem_rdata), .st_issue(st_issue), .lock_bits(lock_bits),
        .fuse_low(fuse_low), .fuse_high(fuse_high), .fuse_ext(fuse_ext),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ctl_wr   = 1'b0;
        ld_issue = 1'b0;
        st_issue = 1'b0;
    endtask

    task automatic arm();
        ctl_wr    = 1'b1;
        ctl_wdata = 8'h09;
        step();
    endtask

    task automatic load(input logic [15:0] p);
        ld_issue = 1'b1;
        ld_ptr   = p;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        check("R1 ctl_bits", ctl_bits, 8'h00);
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_arm_codes();
        ctl_wr = 1'b1; ctl_wdata = 8'h08; step();
        check("R2 select only", ctl_bits, 8'h00);
        ctl_wr = 1'b1; ctl_wdata = 8'h01; step();
        check("R2 go only", ctl_bits, 8'h00);
        arm();
        check("R2 armed", ctl_bits, 8'h09);
        step(); step(); step();
    endtask

    task automatic t_decode();
        arm(); load(16'h0000);
        check("R4 low", rd_data, LOW);
        check("R3 valid", {7'd0, rd_valid}, 8'h01);
        check("R7 cleared", ctl_bits, 8'h00);
        load(16'h0000);
        check("R7 later load", rd_data, PM);
        arm(); load(16'h0001);
        check("R4 R5 lock", rd_data, {2'b11, LOCK});
        arm(); load(16'h0002);
        check("R4 R5 ext", rd_data, {5'b11111, EXT});
        arm(); load(16'h0003);
        check("R4 high", rd_data, HIGH);
    endtask

    task automatic t_far_ptr();
        arm(); load(16'h0104);
        check("R6 far pointer", rd_data, 8'hFF);
        check("R6 closed", ctl_bits, 8'h00);
    endtask

    task automatic t_last_edge();
        arm(); step(); step();
        check("R3 still armed", ctl_bits, 8'h09);
        load(16'h0003);
        check("R3 third edge", rd_data, HIGH);
    endtask

    task automatic t_expiry();
        arm(); step(); step(); step();
        check("R8 expired", ctl_bits, 8'h00);
        load(16'h0001);
        check("R8 fourth edge", rd_data, PM);
    endtask

    task automatic t_store();
        arm();
        st_issue = 1'b1; step();
        check("R9 store closes", ctl_bits, 8'h00);
        load(16'h0000);
        check("R9 after store", rd_data, PM);
        arm(); load(16'h0000);
        check("R9 bytes unchanged", rd_data, LOW);
    endtask

    task automatic t_plain();
        pmem_rdata = 8'h5A;
        load(16'h0002);
        check("R10 plain load", rd_data, 8'h5A);
        pmem_rdata = PM;
    endtask

    task automatic t_same_edge();
        ctl_wr = 1'b1; ctl_wdata = 8'h09; ld_issue = 1'b1; ld_ptr = 16'h0000;
        step();
        check("R11 same edge", rd_data, PM);
        check("R11 still armed", ctl_bits, 8'h09);
        load(16'h0003);
        check("R11 next edge", rd_data, HIGH);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00; ld_issue = 1'b0;
        ld_ptr = 16'h0000; st_issue = 1'b0; pmem_rdata = PM;
        lock_bits = LOCK; fuse_low = LOW; fuse_high = HIGH; fuse_ext = EXT;
        @(negedge clk);
        t_reset();
        t_arm_codes();
        t_decode();
        t_far_ptr();
        t_last_edge();
        t_expiry();
        t_store();
        t_plain();
        t_same_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule